// File: doc/BRIEF.md
# Two-Deep Latched Interrupt Register Bank

This block gathers 32 interrupt source lines into one bank of four registers that software reaches through a plain register port. A rising edge on a source line is latched as a pending event. Each pending bit can hold two occurrences, so a second edge that arrives before software has serviced the first is not lost. Writing a one to a pending bit removes one occurrence. If a second occurrence was queued, the bit reads one again, so a full clear needs two writes.

A mask register decides which sources may latch events at all. An enable register decides which pending bits drive the single combined interrupt output. A status register shows the live level of every line. A driver quiesces the bank in this order: write all ones to the mask, write zero to the enable, read the enable back, then do two rounds of writing all ones to the pending register and reading it back.

The register port is a control path with no back-pressure. A request is taken in every cycle in which `req_valid_i` is high. The result of a read appears on the next cycle with `rd_valid_o`.

Top module: `irq_pending_bank`

## Requirements
- R1: After reset the mask reads all ones, the enable reads zero, the pending register reads zero with nothing queued, and `irq_o` is low.
- R2: Address 0 (status) returns the live level of every source line, whatever the mask and enable hold.
- R3: A rising edge on a source whose mask bit is 0 sets its pending bit at address 2. An edge on a masked source is not captured. A line held high latches only one event.
- R4: A second edge on a bit that is already pending is queued. The first clear of that bit leaves it reading 1, and a second clear makes it read 0.
- R5: A third edge while both occurrences are held is dropped, so two clears always bring the bit back to 0.
- R6: A write to address 2 removes one occurrence from each bit written as 1 and leaves bits written as 0 untouched. Writing back a value that was read clears only the bits that were seen set.
- R7: Setting a mask bit does not remove occurrences that are already pending.
- R8: `irq_o` is high exactly when some bit is both pending and set in the enable register at address 3.
- R9: When a clear and a new edge hit the same bit in the same cycle, the clear removes one occurrence and the edge then adds one. A bit with no occurrences ends with one, and a bit with two stays at two.
- R10: The mask (address 1) and the enable (address 3) read back the last value written. Read data appears with `rd_valid_o` one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt source lines |
| req_valid_i | input | 1 | Register request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | 0 status, 1 mask, 2 pending, 3 enable |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest states to reach are the full two-occurrence state on a bit, a third edge that arrives while that state is held, and a clear and an edge that land on the same bit in the same cycle. The bench reaches the first two by pulsing one source line one, two or three times back to back, and it sweeps this across all 32 bits. It reaches the third by driving a pending-register write and a source edge in the same cycle, both on an empty bit and on a bit holding two occurrences. A model kept in the bench tracks the occurrence count of every bit, and each read-back is compared against that model.

// File: rtl/irqb_pkg.sv
`timescale 1ns/1ps
package irqb_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_PEND   = 2'd2,
    SEL_ENABLE = 2'd3
  } reg_sel_e;

  localparam int unsigned SLOT_DEPTH = 2;
endpackage

// File: rtl/irqb_edge.sv
`timescale 1ns/1ps
module irqb_edge #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R3: a rise is only reported when the line was low one cycle earlier
  assert_rise_needs_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |-> (($past(lvl_i) & rise_o) == '0))
    else $error("edge reported on a line that was already high");
endmodule

// File: rtl/irqb_slot.sv
`timescale 1ns/1ps
module irqb_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic clr_i,
  output logic pend_o
);
  import irqb_pkg::*;
  localparam logic [1:0] FULL = 2'(SLOT_DEPTH);

  logic [1:0] cnt_q, cnt_dec, cnt_nxt;

  always_comb begin
    cnt_dec = (clr_i && cnt_q != 2'd0) ? cnt_q - 2'd1 : cnt_q;
    cnt_nxt = (ev_i && cnt_dec != FULL) ? cnt_dec + 2'd1 : cnt_dec;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cnt_q <= 2'd0;
    else         cnt_q <= cnt_nxt;
  end

  assign pend_o = (cnt_q != 2'd0);

  assert_cnt_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL) else $error("occurrence count out of range");

  assert_shift_forward_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ev_i && cnt_q == FULL) |=> (cnt_q == 2'd1))
    else $error("second occurrence did not move forward");

  assert_drop_third_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && !clr_i && cnt_q == FULL) |=> (cnt_q == FULL))
    else $error("third occurrence changed a full slot");

  assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_i && !clr_i) |=> $stable(cnt_q))
    else $error("slot changed without event or clear");

  assert_edge_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && clr_i) |=> pend_o)
    else $error("same-cycle edge lost to clear");
endmodule

// File: rtl/irqb_regfile.sv
`timescale 1ns/1ps
module irqb_regfile #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_valid_i,
  input  logic         req_write_i,
  input  logic [1:0]   req_addr_i,
  input  logic [N-1:0] req_wdata_i,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] clr_o,
  output logic         rd_valid_o,
  output logic [N-1:0] rd_data_o
);
  import irqb_pkg::*;

  reg_sel_e     sel;
  logic         wr_go, rd_go;
  logic [N-1:0] mask_q, en_q, rd_mux;

  assign sel   = reg_sel_e'(req_addr_i);
  assign wr_go = req_valid_i && req_write_i;
  assign rd_go = req_valid_i && !req_write_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mask_q <= '1;
      en_q   <= '0;
    end else if (wr_go) begin
      if (sel == SEL_MASK)   mask_q <= req_wdata_i;
      if (sel == SEL_ENABLE) en_q   <= req_wdata_i;
    end
  end

  assign clr_o = (wr_go && sel == SEL_PEND) ? req_wdata_i : '0;

  always_comb begin
    unique case (sel)
      SEL_STATUS: rd_mux = status_i;
      SEL_MASK:   rd_mux = mask_q;
      SEL_PEND:   rd_mux = pend_i;
      SEL_ENABLE: rd_mux = en_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_go;
      if (rd_go) rd_data_o <= rd_mux;
    end
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;

  assert_mask_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && sel == SEL_MASK) |=> (mask_o == $past(req_wdata_i)))
    else $error("mask write not taken");

  assert_enable_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && sel == SEL_ENABLE) |=> (en_o == $past(req_wdata_i)))
    else $error("enable write not taken");

  assert_rd_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go |=> rd_valid_o)
    else $error("read data not valid one cycle after request");
endmodule

// File: rtl/irq_pending_bank.sv
`timescale 1ns/1ps
module irq_pending_bank #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [1:0]         req_addr_i,
  input  logic [NUM_SRC-1:0] req_wdata_i,
  output logic               rd_valid_o,
  output logic [NUM_SRC-1:0] rd_data_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] rise, mask, en, clr, pend, take;

  irqb_edge #(.N(NUM_SRC)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(src_i), .rise_o(rise)
  );

  irqb_regfile #(.N(NUM_SRC)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .status_i(src_i), .pend_i(pend),
    .mask_o(mask), .en_o(en), .clr_o(clr),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  assign take = rise & ~mask;

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_slot
    irqb_slot u_slot (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .ev_i(take[b]), .clr_i(clr[b]), .pend_o(pend[b])
    );
  end

  assign irq_o = |(pend & en);

  assert_irq_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en != '0))
    else $error("interrupt raised with nothing enabled");

  assert_masked_no_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((rise & mask) != '0) && clr == '0) |=> ((pend & ~$past(pend) & $past(rise & mask)) == '0))
    else $error("masked edge entered pending register");
endmodule

// File: tb/test_irq_pending_bank.sv
`timescale 1ns/1ps
module test_irq_pending_bank;
  localparam int N = 32;
  localparam logic [1:0] A_STAT = 2'd0, A_MASK = 2'd1, A_PEND = 2'd2, A_EN = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0, wdata = '0;
  logic req_v = 1'b0, req_w = 1'b0;
  logic [1:0] addr = '0;
  logic rd_v, irq;
  logic [N-1:0] rd_d;

  int total = 0, bad = 0;
  int cnt [N];
  logic [N-1:0] m_mask = '1, m_en = '0;

  always #2 clk = ~clk;

  irq_pending_bank #(.NUM_SRC(N)) i_irq_pending_bank (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .req_valid_i(req_v), .req_write_i(req_w), .req_addr_i(addr),
    .req_wdata_i(wdata), .rd_valid_o(rd_v), .rd_data_o(rd_d), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_pend();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (cnt[i] > 0);
    return v;
  endfunction

  function automatic void m_clear(input logic [N-1:0] w);
    for (int i = 0; i < N; i++) if (w[i] && cnt[i] > 0) cnt[i]--;
  endfunction

  function automatic void m_edge(input logic [N-1:0] b);
    for (int i = 0; i < N; i++) if (b[i] && !m_mask[i] && cnt[i] < 2) cnt[i]++;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    req_v = 1'b1; req_w = 1'b1; addr = a; wdata = d;
    if (a == A_MASK) m_mask = d;
    if (a == A_EN) m_en = d;
    if (a == A_PEND) m_clear(d);
    @(negedge clk);
    req_v = 1'b0; req_w = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    req_v = 1'b1; req_w = 1'b0; addr = a;
    @(negedge clk);
    req_v = 1'b0;
    check("R10 rd_valid", {{(N-1){1'b0}}, rd_v}, {{(N-1){1'b0}}, 1'b1});
    d = rd_d;
  endtask

  task automatic pulse(input logic [N-1:0] b);
    src = b; m_edge(b);
    @(negedge clk);
    src = '0;
    @(negedge clk);
  endtask

  task automatic check_pend(input string tag);
    logic [N-1:0] v;
    rd(A_PEND, v);
    check(tag, v, exp_pend());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] pats [6];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0001; pats[2] = 32'h8000_0000;
    pats[3] = 32'hA5A5_5A5A; pats[4] = 32'h0F0F_00F0; pats[5] = 32'h1234_5678;
    for (int i = 0; i < N; i++) cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_MASK, v); check("R1 mask", v, '1);
    rd(A_EN, v);   check("R1 enable", v, '0);
    rd(A_PEND, v); check("R1 pending", v, '0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R2 status with all masked, R3 masked edges not captured
    for (int p = 0; p < 6; p++) begin
      src = pats[p];
      @(negedge clk);
      rd(A_STAT, v); check("R2 status masked", v, pats[p]);
      src = '0;
      @(negedge clk);
    end
    check_pend("R3 masked edges ignored");

    // R10 mask/enable readback
    wr(A_MASK, 32'h0F0F_1234); rd(A_MASK, v); check("R10 mask readback", v, 32'h0F0F_1234);
    wr(A_EN, 32'hC3C3_0001);   rd(A_EN, v);   check("R10 enable readback", v, 32'hC3C3_0001);
    wr(A_EN, '0);
    wr(A_MASK, '0);

    // R2 status while unmasked (edges also captured), then clear twice
    src = 32'h5A5A_A5A5; m_edge(src);
    @(negedge clk);
    rd(A_STAT, v); check("R2 status unmasked", v, 32'h5A5A_A5A5);
    src = '0; @(negedge clk);
    check_pend("R3 unmasked capture");
    wr(A_PEND, '1); wr(A_PEND, '1);
    check_pend("R4 double clear zero");

    // R3 held level latches once
    src = 32'h0000_0100; m_edge(src);
    repeat (5) @(negedge clk);
    src = '0; @(negedge clk);
    wr(A_PEND, 32'h0000_0100);
    check_pend("R3 held level single event");

    // R4/R5 sweep every bit with 1..3 events
    for (int i = 0; i < N; i++) begin
      for (int k = 1; k <= 3; k++) begin
        for (int e = 0; e < k; e++) pulse(32'd1 << i);
        check_pend("R3 bit captured");
        wr(A_PEND, 32'd1 << i);
        check_pend("R4 first clear");
        wr(A_PEND, 32'd1 << i);
        check_pend("R5 second clear zero");
      end
    end

    // R6 read and write back clears only seen bits, second level remains
    for (int p = 1; p < 6; p++) begin
      pulse(pats[p]); pulse(pats[p]); pulse(pats[(p + 1) % 6]);
      rd(A_PEND, v); check("R6 read before writeback", v, exp_pend());
      wr(A_PEND, v);
      check_pend("R6 writeback leaves second level");
      wr(A_PEND, 32'h0000_FFFF);
      check_pend("R6 partial clear");
      wr(A_PEND, '1); wr(A_PEND, '1);
      check_pend("R6 full quiesce");
    end

    // R7 masking after capture keeps queued occurrences
    pulse(32'h0000_0030); pulse(32'h0000_0010);
    wr(A_MASK, '1);
    check_pend("R7 mask keeps pending");
    wr(A_PEND, 32'h0000_0030);
    check_pend("R7 second level kept under mask");
    pulse(32'h0000_0020);
    check_pend("R7 masked edge ignored");
    wr(A_PEND, '1); wr(A_MASK, '0);

    // R8 combined output
    pulse(32'h0000_0400);
    check("R8 irq low without enable", {31'd0, irq}, 32'd0);
    wr(A_EN, 32'h0000_0800);
    check("R8 irq low other bit enabled", {31'd0, irq}, 32'd0);
    wr(A_EN, 32'h0000_0C00);
    check("R8 irq high", {31'd0, irq}, {31'd0, |(exp_pend() & m_en)});
    wr(A_PEND, 32'h0000_0400);
    check("R8 irq low after clear", {31'd0, irq}, 32'd0);
    wr(A_EN, '0);

    // R9 clear and edge in the same cycle
    for (int pre = 0; pre <= 2; pre++) begin
      for (int e = 0; e < pre; e++) pulse(32'h0001_0000);
      src = 32'h0001_0000; req_v = 1'b1; req_w = 1'b1; addr = A_PEND; wdata = 32'h0001_0000;
      m_clear(32'h0001_0000); m_edge(32'h0001_0000);
      @(negedge clk);
      req_v = 1'b0; req_w = 1'b0; src = '0;
      @(negedge clk);
      check_pend("R9 edge kept on clear");
      wr(A_PEND, 32'h0001_0000);
      check_pend("R9 after one clear");
      wr(A_PEND, 32'h0001_0000);
      check_pend("R9 after two clears");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule